// File: doc/BRIEF.md
# Receive Lane Polarity and Order Trainer

This block sits after the deserializer on the receive side of a three-lane serial link port. Each clock it takes one parallel word per physical lane, 16 or 20 bits wide as set by a static width input. While the link comes up, every logical lane sends its own fixed training pattern. The block recognises each pattern in true or complemented form, so it learns which physical lane carries which logical lane and whether that lane's differential pair was swapped.

The block locks that lane map and inversion mask once it has seen the same valid result on enough consecutive words. From then on every received word has its polarity corrected and its lanes put back in logical order through a 3-to-3 crossbar. The corrected word is handed to the link layer one clock later. A synchronous retrain input drops the lock and starts training again.

Top module: `lane_align_trainer`

## Requirements
- R1: With `cfg_wide`=1 all 20 bits of a lane are compared and passed. With `cfg_wide`=0 only bits 15:0 are compared, bits 19:16 of every input lane are ignored, and bits 19:16 of every output lane are 0.
- R2: The 16-bit training patterns are 0x0F0F for logical lane 0, 0x3C3C for lane 1 and 0x5A5A for lane 2. In 20-bit mode each is extended by placing its low nibble on top, giving 0xF0F0F, 0xC3C3C and 0xA5A5A. A true match gives inversion bit 0 and a complemented match gives 1; `inv_mask` bit p belongs to physical lane p.
- R3: Each of the six lane orderings is recovered. `lane_map` bits [2p+1:2p] hold the logical lane carried by physical lane p (lane p in `rx_lanes` is bits [20p+19:20p]).
- R4: If two physical lanes match the same logical pattern, `map_err` goes to 1 and the block does not lock. `map_err` clears on the next valid word or on retrain.
- R5: A word in which any lane matches no pattern, in true or complemented form, resets the consecutive count, so lock needs 8 fresh matching words after it.
- R6: `locked` rises at the clock edge that samples the 8th consecutive word carrying the same complete, valid map and mask. A word with a different valid result restarts the count at 1.
- R7: While locked, `lane_map` and `inv_mask` stay fixed whatever arrives on the lanes.
- R8: While locked, output lane l equals the physical lane that carries l, XORed with that lane's inversion bit. The result and `out_valid` appear one clock after the input.
- R9: `retrain`=1 at a clock edge clears `locked`, `lane_map`, `inv_mask`, `map_err` and `out_valid`, and restarts training.
- R10: After reset, `locked`, `out_valid`, `map_err`, `lane_map`, `inv_mask` and `out_lanes` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1 = 20-bit lanes, 0 = 16-bit lanes (static) |
| retrain | input | 1 | Synchronous request to drop lock and retrain |
| rx_lanes | input | 60 | Three physical lane words, lane p at [20p+19:20p] |
| out_lanes | output | 60 | Corrected lanes in logical order, lane l at [20l+19:20l] |
| out_valid | output | 1 | `out_lanes` holds corrected data |
| locked | output | 1 | Map and mask are locked |
| lane_map | output | 6 | Logical lane of each physical lane, two bits each |
| inv_mask | output | 3 | Inversion bit of each physical lane |
| map_err | output | 1 | Two physical lanes claimed the same logical lane |

## Verification
The assertions assume that `rst_n` is low at time zero and that `cfg_wide` only changes while the block is held in retrain or reset, so a locked map never comes from words of mixed widths. The directed stimulus sets the width before each training task and pulses retrain at the start of every scenario. Lane words change only on falling clock edges, so every word is seen whole at one rising edge.

// File: rtl/lat_pkg.sv
package lat_pkg;
  localparam int NLANES = 3;
  localparam int IDXW   = 2;
  localparam int WMAX   = 20;
  localparam int WNARROW = 16;

  // 16-bit training pattern of each logical lane
  function automatic logic [WNARROW-1:0] base_pat(input int idx);
    case (idx)
      0:       base_pat = 16'h0F0F;
      1:       base_pat = 16'h3C3C;
      default: base_pat = 16'h5A5A;
    endcase
  endfunction

  // pattern widened by repeating its low nibble on top
  function automatic logic [WMAX-1:0] wide_pat(input int idx);
    logic [WNARROW-1:0] b;
    b = base_pat(idx);
    wide_pat = {b[WMAX-WNARROW-1:0], b};
  endfunction
endpackage

// File: rtl/lat_lane_class.sv
module lat_lane_class
  import lat_pkg::*;
#(
  parameter int W = WMAX
) (
  input  logic [W-1:0]    word,
  input  logic            wide,
  output logic            hit,
  output logic [IDXW-1:0] idx,
  output logic            inv
);
  localparam logic [W-1:0] MASK_W = {W{1'b1}};
  localparam logic [W-1:0] MASK_N = {{(W-WNARROW){1'b0}}, {WNARROW{1'b1}}};

  logic [W-1:0] mask;
  logic [W-1:0] masked;

  always_comb begin
    mask   = wide ? MASK_W : MASK_N;
    masked = word & mask;
    hit    = 1'b0;
    idx    = '0;
    inv    = 1'b0;
    for (int k = 0; k < NLANES; k++) begin
      logic [W-1:0] p;
      p = wide_pat(k) & mask;
      if (!hit && masked == p) begin
        hit = 1'b1;
        idx = IDXW'(k);
        inv = 1'b0;
      end else if (!hit && masked == (~p & mask)) begin
        hit = 1'b1;
        idx = IDXW'(k);
        inv = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lat_lock_ctrl.sv
module lat_lock_ctrl
  import lat_pkg::*;
#(
  parameter int LOCK_WORDS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   retrain,
  input  logic [NLANES-1:0]      hit,
  input  logic [NLANES*IDXW-1:0] cand_map,
  input  logic [NLANES-1:0]      cand_inv,
  output logic                   locked,
  output logic [NLANES*IDXW-1:0] map_q,
  output logic [NLANES-1:0]      inv_q,
  output logic                   err
);
  localparam int CW = $clog2(LOCK_WORDS + 1);

  logic [CW-1:0]            cnt_q, cnt_d;
  logic [NLANES*IDXW-1:0]   prev_map_q, prev_map_d, map_d;
  logic [NLANES-1:0]        prev_inv_q, prev_inv_d, inv_d;
  logic                     locked_d, err_d;
  logic                     all_hit, dup, same;

  always_comb begin
    all_hit = &hit;
    dup     = 1'b0;
    for (int a = 0; a < NLANES; a++)
      for (int b = a + 1; b < NLANES; b++)
        if (cand_map[a*IDXW +: IDXW] == cand_map[b*IDXW +: IDXW]) dup = 1'b1;
    same = (cnt_q != '0) && (cand_map == prev_map_q) && (cand_inv == prev_inv_q);
  end

  always_comb begin
    cnt_d      = cnt_q;
    prev_map_d = prev_map_q;
    prev_inv_d = prev_inv_q;
    map_d      = map_q;
    inv_d      = inv_q;
    locked_d   = locked;
    err_d      = err;
    if (retrain) begin
      cnt_d      = '0;
      prev_map_d = '0;
      prev_inv_d = '0;
      map_d      = '0;
      inv_d      = '0;
      locked_d   = 1'b0;
      err_d      = 1'b0;
    end else if (!locked) begin
      if (all_hit && dup) begin
        err_d = 1'b1;
        cnt_d = '0;
      end else if (all_hit) begin
        err_d      = 1'b0;
        prev_map_d = cand_map;
        prev_inv_d = cand_inv;
        if (same) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(LOCK_WORDS - 1)) begin
            locked_d = 1'b1;
            map_d    = cand_map;
            inv_d    = cand_inv;
          end
        end else begin
          cnt_d = CW'(1);
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      prev_map_q <= '0;
      prev_inv_q <= '0;
      map_q      <= '0;
      inv_q      <= '0;
      locked     <= 1'b0;
      err        <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      prev_map_q <= prev_map_d;
      prev_inv_q <= prev_inv_d;
      map_q      <= map_d;
      inv_q      <= inv_d;
      locked     <= locked_d;
      err        <= err_d;
    end
  end
endmodule

// File: rtl/lat_xbar.sv
module lat_xbar
  import lat_pkg::*;
#(
  parameter int W = WMAX
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   wide,
  input  logic [NLANES*W-1:0]    rx,
  input  logic [NLANES*IDXW-1:0] map,
  input  logic [NLANES-1:0]      inv,
  output logic [NLANES*W-1:0]    tx,
  output logic                   tx_valid
);
  localparam logic [W-1:0] MASK_N = {{(W-WNARROW){1'b0}}, {WNARROW{1'b1}}};

  logic [NLANES*W-1:0] corr;
  logic [W-1:0]        mask;

  always_comb begin
    mask = wide ? {W{1'b1}} : MASK_N;
    corr = '0;
    for (int l = 0; l < NLANES; l++)
      for (int p = 0; p < NLANES; p++)
        if (map[p*IDXW +: IDXW] == IDXW'(l))
          corr[l*W +: W] = corr[l*W +: W] | ((rx[p*W +: W] ^ {W{inv[p]}}) & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx       <= '0;
      tx_valid <= 1'b0;
    end else begin
      tx       <= en ? corr : '0;
      tx_valid <= en;
    end
  end
endmodule

// File: rtl/lane_align_trainer.sv
module lane_align_trainer
  import lat_pkg::*;
#(
  parameter int W          = WMAX,
  parameter int LOCK_WORDS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wide,
  input  logic                   retrain,
  input  logic [NLANES*W-1:0]    rx_lanes,
  output logic [NLANES*W-1:0]    out_lanes,
  output logic                   out_valid,
  output logic                   locked,
  output logic [NLANES*IDXW-1:0] lane_map,
  output logic [NLANES-1:0]      inv_mask,
  output logic                   map_err
);
  logic [NLANES-1:0]      hit;
  logic [NLANES*IDXW-1:0] cand_map;
  logic [NLANES-1:0]      cand_inv;

  for (genvar p = 0; p < NLANES; p++) begin : g_lane
    lat_lane_class #(.W(W)) i_class (
      .word (rx_lanes[p*W +: W]),
      .wide (cfg_wide),
      .hit  (hit[p]),
      .idx  (cand_map[p*IDXW +: IDXW]),
      .inv  (cand_inv[p])
    );
  end

  lat_lock_ctrl #(.LOCK_WORDS(LOCK_WORDS)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .retrain  (retrain),
    .hit      (hit),
    .cand_map (cand_map),
    .cand_inv (cand_inv),
    .locked   (locked),
    .map_q    (lane_map),
    .inv_q    (inv_mask),
    .err      (map_err)
  );

  lat_xbar #(.W(W)) i_xbar (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (locked && !retrain),
    .wide     (cfg_wide),
    .rx       (rx_lanes),
    .map      (lane_map),
    .inv      (inv_mask),
    .tx       (out_lanes),
    .tx_valid (out_valid)
  );
endmodule

// File: rtl/lat_checker.sv
module lat_checker
  import lat_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   retrain,
  input logic                   out_valid,
  input logic                   locked,
  input logic [NLANES*IDXW-1:0] lane_map,
  input logic [NLANES-1:0]      inv_mask,
  input logic                   map_err
);
  AST_VALID_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(locked) && !$past(retrain)); // R8

  AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> ($stable(lane_map) && $stable(inv_mask))); // R7

  AST_RETRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    retrain |=> (!locked && !out_valid && !map_err && lane_map == '0 && inv_mask == '0)); // R9

  AST_MAP_IS_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (lane_map[1:0] != lane_map[3:2] && lane_map[1:0] != lane_map[5:4] &&
                lane_map[3:2] != lane_map[5:4] && lane_map[1:0] != 2'd3 &&
                lane_map[3:2] != 2'd3 && lane_map[5:4] != 2'd3)); // R3

  AST_ERR_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    map_err |-> !locked); // R4
endmodule

bind lane_align_trainer lat_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .retrain   (retrain),
  .out_valid (out_valid),
  .locked    (locked),
  .lane_map  (lane_map),
  .inv_mask  (inv_mask),
  .map_err   (map_err)
);

// File: tb/test_lane_align_trainer.sv
module test_lane_align_trainer;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wide = 1'b1;
  logic        retrain = 1'b0;
  logic [59:0] rx_lanes = '0;
  logic [59:0] out_lanes;
  logic        out_valid, locked, map_err;
  logic [5:0]  lane_map;
  logic [2:0]  inv_mask;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  lane_align_trainer i_lane_align_trainer (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .retrain(retrain),
    .rx_lanes(rx_lanes), .out_lanes(out_lanes), .out_valid(out_valid),
    .locked(locked), .lane_map(lane_map), .inv_mask(inv_mask), .map_err(map_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] pat(input int k);
    case (k)
      0: pat = 20'hF0F0F;
      1: pat = 20'hC3C3C;
      default: pat = 20'hA5A5A;
    endcase
  endfunction

  // physical lane p carries logical lane lg[p]; top nibble forced to nib in 16-bit mode
  function automatic logic [59:0] mk(input int l0, input int l1, input int l2,
                                     input logic [2:0] inv, input logic wide, input logic [3:0] nib);
    logic [59:0] w;
    int lg[3];
    lg[0] = l0; lg[1] = l1; lg[2] = l2;
    for (int p = 0; p < 3; p++) begin
      logic [19:0] v;
      v = pat(lg[p]) ^ {20{inv[p]}};
      if (!wide) v[19:16] = nib;
      w[p*20 +: 20] = v;
    end
    return w;
  endfunction

  task automatic send(input logic [59:0] w);
    @(negedge clk);
    rx_lanes = w;
    @(posedge clk);
    #1;
  endtask

  task automatic do_retrain();
    @(negedge clk);
    retrain = 1'b1;
    @(posedge clk);
    #1;
    retrain = 1'b0;
  endtask

  task automatic t_reset();
    chk(!locked && !out_valid && !map_err, "R10 flags", {locked, out_valid, map_err}, 0);
    chk(lane_map == 0 && inv_mask == 0 && out_lanes == 0, "R10 state", {lane_map, inv_mask}, 0);
  endtask

  task automatic t_train(input int l0, input int l1, input int l2, input logic [2:0] inv,
                         input logic wide, input string tag);
    logic [59:0] w;
    cfg_wide = wide;
    do_retrain();
    w = mk(l0, l1, l2, inv, wide, 4'h6);
    for (int i = 0; i < 7; i++) send(w);
    chk(!locked, {"R6 not yet locked ", tag}, locked, 0);
    send(w);
    chk(locked, {"R6 locked after 8 ", tag}, locked, 1);
    chk(lane_map == {2'(l2), 2'(l1), 2'(l0)}, {"R3 map ", tag}, lane_map, {2'(l2), 2'(l1), 2'(l0)});
    chk(inv_mask == inv, {"R2 inv ", tag}, inv_mask, inv);
  endtask

  task automatic t_data(input int l0, input int l1, input int l2, input logic [2:0] inv,
                        input logic wide, input logic [59:0] d);
    logic [59:0] exp;
    int lg[3];
    lg[0] = l0; lg[1] = l1; lg[2] = l2;
    exp = '0;
    for (int p = 0; p < 3; p++) begin
      logic [19:0] v;
      v = d[p*20 +: 20] ^ {20{inv[p]}};
      if (!wide) v[19:16] = 4'h0;
      exp[lg[p]*20 +: 20] = v;
    end
    send(d);
    chk(out_valid, "R8 valid", out_valid, 1);
    chk(out_lanes == exp, wide ? "R8 data" : "R1 narrow data", out_lanes, exp);
  endtask

  task automatic t_dup();
    cfg_wide = 1'b1;
    do_retrain();
    for (int i = 0; i < 10; i++) send(mk(0, 0, 2, 3'b000, 1'b1, 4'h0));
    chk(map_err, "R4 err set", map_err, 1);
    chk(!locked, "R4 no lock", locked, 0);
    send(mk(0, 1, 2, 3'b000, 1'b1, 4'h0));
    chk(!map_err, "R4 err clears", map_err, 0);
  endtask

  task automatic t_nomatch();
    logic [59:0] w;
    cfg_wide = 1'b1;
    do_retrain();
    w = mk(2, 0, 1, 3'b010, 1'b1, 4'h0);
    for (int i = 0; i < 5; i++) send(w);
    send({w[59:20], 20'h12345});
    for (int i = 0; i < 7; i++) send(w);
    chk(!locked, "R5 count reset by bad lane", locked, 0);
    send(w);
    chk(locked, "R5 lock after 8 fresh", locked, 1);
  endtask

  task automatic t_change();
    cfg_wide = 1'b1;
    do_retrain();
    for (int i = 0; i < 5; i++) send(mk(0, 1, 2, 3'b000, 1'b1, 4'h0));
    for (int i = 0; i < 7; i++) send(mk(1, 2, 0, 3'b100, 1'b1, 4'h0));
    chk(!locked, "R6 change restarts count", locked, 0);
    send(mk(1, 2, 0, 3'b100, 1'b1, 4'h0));
    chk(locked && lane_map == 6'b00_10_01, "R6 locked on new map", lane_map, 6'b00_10_01);
  endtask

  task automatic t_frozen();
    for (int i = 0; i < 10; i++) send(mk(2, 1, 0, 3'b111, 1'b1, 4'h0));
    chk(lane_map == 6'b00_10_01 && inv_mask == 3'b100, "R7 map frozen", {lane_map, inv_mask},
        {6'b00_10_01, 3'b100});
  endtask

  task automatic t_retrain();
    do_retrain();
    chk(!locked && !out_valid && lane_map == 0 && inv_mask == 0 && !map_err, "R9 cleared",
        {locked, out_valid, lane_map, inv_mask, map_err}, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 3);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_train(0, 1, 2, 3'b000, 1'b1, "identity");
    t_data(0, 1, 2, 3'b000, 1'b1, 60'h12345_6789A_BCDEF);
    t_train(2, 0, 1, 3'b101, 1'b1, "rotated");
    t_data(2, 0, 1, 3'b101, 1'b1, 60'hFEDCB_A9876_54321);
    t_train(1, 0, 2, 3'b010, 1'b1, "swap01");
    t_data(1, 0, 2, 3'b010, 1'b1, 60'h00FFF_AAAAA_13579);
    t_train(2, 1, 0, 3'b111, 1'b0, "narrow");
    t_data(2, 1, 0, 3'b111, 1'b0, 60'hABCDE_12345_F0F0F);
    t_dup();
    t_nomatch();
    t_change();
    t_frozen();
    t_retrain();
    send(mk(0, 1, 2, 3'b000, 1'b1, 4'h0));
    chk(!out_valid, "R9 no output after retrain", out_valid, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule